// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a synchronous binary up-counter built from 4-bit stages that are chained into one wider counter. Every change of state happens on the rising edge of the clock. At each edge an active-low clear, an active-low parallel load and two count enables decide what the counter does. Clear wins over load, and load wins over counting. One count enable is shared by every stage. The other is a carry enable that passes from stage to stage and also gates the terminal-count flag.

The terminal-count flag is high while the carry enable is high and every counter bit is one. The flag is combinational on the carry enable, so a higher-level counter can chain this block by driving its own carry enable from the flag. If a decoded count is fed back to the clear input, the counter runs through a shortened cycle. The parameter `NUM_STAGES` sets how many 4-bit stages the block has. Stage k counts only when every stage below it is at all ones, so the block behaves as a single counter of 4*NUM_STAGES bits.

Top module: `cascade_counter`

## Requirements
- R1: When `clrN` is 0 at a rising edge, `qOut` becomes all zeros after that edge. The load, the data and both enables have no effect.
- R2: When `clrN` is 1 and `loadN` is 0 at a rising edge, `qOut` takes the value of `dIn` after that edge, whatever the two enables are.
- R3: When `clrN` and `loadN` are both 1 and both `cntEnPar` and `cntEnCarry` are 1, `qOut` increases by one at the edge. The increase spans the full width, with a carry from each 4-bit stage into the next (0x0F becomes 0x10).
- R4: When `clrN` and `loadN` are both 1 and either `cntEnPar` or `cntEnCarry` is 0, `qOut` keeps its value over the edge.
- R5: Counting from all ones gives all zeros.
- R6: `termCnt` is 1 exactly when `cntEnCarry` is 1 and `qOut` is all ones. It follows `cntEnCarry` combinationally, without waiting for a clock edge.
- R7: A change of `clrN` between clock edges leaves `qOut` unchanged until the next rising edge.
- R8: With `NUM_STAGES` stages the counter is 4*NUM_STAGES bits wide. Stage k, for k > 0, advances only when `cntEnCarry` is 1 and every lower stage is at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Synchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| cntEnPar | input | 1 | Count enable shared by all stages |
| cntEnCarry | input | 1 | Carry enable; feeds the stage chain and gates `termCnt` |
| dIn | input | 4*NUM_STAGES | Value to load |
| qOut | output | 4*NUM_STAGES | Counter value |
| termCnt | output | 1 | Terminal count: carry enable high and counter all ones |

## Verification
The port-level properties assume that every input has a known value at each rising edge. They also assume that at least one clear has been sampled, because until then the counter value is undefined; the properties stay disarmed until that first clear is seen. The bench drives every input to a defined level from time zero and starts each phase with a clear. It changes inputs only on the falling edge, except in the two cases that deliberately toggle `clrN` or `cntEnCarry` in the middle of a cycle, and those two cases are checked before the next rising edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Strobes the control hands to one datapath stage for the next edge.
  typedef struct packed {
    logic clr;   // force stage to zero
    logic ld;    // copy data slice into stage
    logic inc;   // advance stage by one
  } stageStrobe_t;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                clrN,
  input  logic                                loadN,
  input  logic                                cntEnPar,
  input  logic                                cntEnCarry,
  input  logic [NUM_STAGES-1:0]               stageMax,
  output stageStrobe_t [NUM_STAGES-1:0]       strobes,
  output logic                                termCnt
);

  logic [NUM_STAGES-1:0] carryIn;
  logic                  doClr;
  logic                  doLd;
  logic                  mayCnt;

  // Clear has priority over load, and load over counting.
  assign doClr  = ~clrN;
  assign doLd   = clrN & ~loadN;
  assign mayCnt = clrN & loadN & cntEnPar;

  assign carryIn[0] = cntEnCarry;

  for (genvar k = 1; k < NUM_STAGES; k++) begin : g_chain
    assign carryIn[k] = carryIn[k-1] & stageMax[k-1];
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_strb
    assign strobes[k].clr = doClr;
    assign strobes[k].ld  = doLd;
    assign strobes[k].inc = mayCnt & carryIn[k];
  end

  assign termCnt = carryIn[NUM_STAGES-1] & stageMax[NUM_STAGES-1];

  // R8: an upper stage may only advance while the stage below is advancing past its top value
  for (genvar k = 1; k < NUM_STAGES; k++) begin : g_chk
    p_upper_needs_lower_r8: assert property (@(posedge clk) disable iff (!clrN)
      strobes[k].inc |-> (strobes[k-1].inc && stageMax[k-1]));
  end

  // R1: the three strobes are mutually exclusive
  p_strobe_excl_r1: assert property (@(posedge clk)
    $onehot0({strobes[0].clr, strobes[0].ld, strobes[0].inc}));

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int STAGE_BITS = 4
) (
  input  logic                  clk,
  input  stageStrobe_t          strb,
  input  logic [STAGE_BITS-1:0] dSlice,
  output logic [STAGE_BITS-1:0] qSlice,
  output logic                  atMax
);

  localparam logic [STAGE_BITS-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (strb.clr)      qSlice <= '0;
    else if (strb.ld)  qSlice <= dSlice;
    else if (strb.inc) qSlice <= qSlice + 1'b1;
  end

  assign atMax = (qSlice == ALL_ONES);

  // R5: advancing from the top value lands on zero
  p_stage_wrap_r5: assert property (@(posedge clk) disable iff (strb.clr)
    (strb.inc && !strb.ld && atMax) |=> (qSlice == '0));

  // R4: with no strobe active the slice keeps its value
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (strb.clr)
    (!strb.ld && !strb.inc && !$isunknown(qSlice)) |=> $stable(qSlice));

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter int STAGE_BITS = 4
) (
  input  logic                              clk,
  input  logic                              clrN,
  input  logic                              loadN,
  input  logic                              cntEnPar,
  input  logic                              cntEnCarry,
  input  logic [STAGE_BITS*NUM_STAGES-1:0]  dIn,
  output logic [STAGE_BITS*NUM_STAGES-1:0]  qOut,
  output logic                              termCnt
);

  localparam int TOTAL_BITS = STAGE_BITS * NUM_STAGES;

  stageStrobe_t [NUM_STAGES-1:0] strobes;
  logic [NUM_STAGES-1:0]         stageMax;

  cnt_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk        (clk),
    .clrN       (clrN),
    .loadN      (loadN),
    .cntEnPar   (cntEnPar),
    .cntEnCarry (cntEnCarry),
    .stageMax   (stageMax),
    .strobes    (strobes),
    .termCnt    (termCnt)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage #(.STAGE_BITS(STAGE_BITS)) u_stage (
      .clk    (clk),
      .strb   (strobes[k]),
      .dSlice (dIn[k*STAGE_BITS +: STAGE_BITS]),
      .qSlice (qOut[k*STAGE_BITS +: STAGE_BITS]),
      .atMax  (stageMax[k])
    );
  end

  // Port-level checks stay disarmed until a clear has been sampled.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clrN) armed <= 1'b1;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    !clrN |=> (qOut == '0));

  p_load_data_r2: assert property (@(posedge clk) disable iff (!armed)
    (clrN && !loadN) |=> (qOut == $past(dIn)));

  p_count_up_r3: assert property (@(posedge clk) disable iff (!armed)
    (clrN && loadN && cntEnPar && cntEnCarry) |=>
      (qOut == TOTAL_BITS'($past(qOut) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clrN && loadN && !(cntEnPar && cntEnCarry)) |=> $stable(qOut));

  p_tc_gated_r6: assert property (@(posedge clk) disable iff (!armed)
    termCnt |-> (cntEnCarry && (&qOut)));

  p_tc_present_r6: assert property (@(posedge clk) disable iff (!armed)
    (cntEnCarry && (&qOut)) |-> termCnt);

endmodule

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int W  = 4 * NS;
  localparam logic [W-1:0] TOP = '1;

  typedef struct packed {
    logic         clrN;
    logic         loadN;
    logic         enP;
    logic         enC;
    logic [W-1:0] d;
    logic [W-1:0] expQ;
    logic         expT;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h00, 1'b0}, // R1 clear
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'hFC, 8'hFC, 1'b0}, // R2 load
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFD, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R6 at top
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R5 wrap
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h01, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h02, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 8'h02, 1'b0}, // R4 par low
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 8'h02, 1'b0}, // R4 carry low
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h0F, 1'b0}, // R2 enables low
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h0F, 1'b0}, // R4
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R8 stage carry
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h00, 1'b0}, // R1 over load
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0}, // R6 carry low
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // R6 hold at top
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R4 R6
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b0}  // R2 over count
  };

  logic         clk = 1'b0;
  logic         clrN = 1'b1;
  logic         loadN = 1'b1;
  logic         cntEnPar = 1'b0;
  logic         cntEnCarry = 1'b0;
  logic [W-1:0] dIn = '0;
  logic [W-1:0] qOut;
  logic         termCnt;

  int nRun = 0;
  int nFail = 0;
  logic [W-1:0] refQ = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_counter #(.NUM_STAGES(NS), .STAGE_BITS(4)) u0 (
    .clk(clk), .clrN(clrN), .loadN(loadN), .cntEnPar(cntEnPar),
    .cntEnCarry(cntEnCarry), .dIn(dIn), .qOut(qOut), .termCnt(termCnt)
  );

  task automatic chk(input string req, input logic [W-1:0] expQ, input logic expT);
    nRun++;
    if (qOut !== expQ || termCnt !== expT) begin
      nFail++;
      $display("FAIL %s: q=%h tc=%b expected q=%h tc=%b", req, qOut, termCnt, expQ, expT);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic e,
                       input logic [W-1:0] d);
    @(negedge clk);
    clrN = c; loadN = l; cntEnPar = p; cntEnCarry = e; dIn = d;
  endtask

  // Reference next-state rule taken from the requirements.
  function automatic logic [W-1:0] nextRef(input logic [W-1:0] q, input logic c,
      input logic l, input logic p, input logic e, input logic [W-1:0] d);
    if (!c)          return '0;
    else if (!l)     return d;
    else if (p && e) return q + 1'b1;
    else             return q;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // Table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].clrN, VECS[i].loadN, VECS[i].enP, VECS[i].enC, VECS[i].d);
      @(posedge clk); #1;
      chk($sformatf("vector %0d", i), VECS[i].expQ, VECS[i].expT);
    end

    // R7: clear dropped mid-cycle has no effect before the edge
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    #1 clrN = 1'b0;
    #1 chk("R7 mid-cycle clear", 8'h3C, 1'b0);
    @(posedge clk); #1;
    chk("R1 clear at edge", 8'h00, 1'b0);

    // R6: terminal count tracks carry enable with no clock edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, TOP);
    @(posedge clk); #1;
    chk("R2 load top", TOP, 1'b0);
    loadN = 1'b1;
    cntEnCarry = 1'b1;
    #1 chk("R6 rise combinational", TOP, 1'b1);
    cntEnCarry = 1'b0;
    #1 chk("R6 fall combinational", TOP, 1'b0);

    // R8: lower stage at top without carry enable does not advance upper stage
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h2F);
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0);
    @(posedge clk); #1;
    chk("R8 carry low blocks chain", 8'h2F, 1'b0);

    // Truncated modulus: clear fed back from decoded 9 gives a count of ten (R1 R3)
    drive(1'b0, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 23; i++) begin
      drive((qOut != 8'h09), 1'b1, 1'b1, 1'b1, '0);
      @(posedge clk); #1;
      chk("R1 R3 modulus ten", 8'((i + 1) % 10), 1'b0);
    end

    // Random patterns against the reference rule, clear and load sometimes together
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    refQ = '0;
    for (int i = 0; i < 400; i++) begin
      logic c, l, p, e;
      logic [W-1:0] d;
      c = ($urandom_range(0, 15) != 0);
      l = ($urandom_range(0, 7) != 0);
      p = ($urandom_range(0, 3) != 0);
      e = ($urandom_range(0, 3) != 0);
      d = W'($urandom_range(0, 255));
      if (i % 5 == 0) d = 8'hFE;
      drive(c, l, p, e, d);
      @(posedge clk); #1;
      refQ = nextRef(refQ, c, l, p, e, d);
      chk("R1 R2 R3 R4 R5 R6 random", refQ, e && (refQ == TOP));
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule